// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a blocking data cache placed between a processor load/store port and a slower main memory. It holds 1024 lines of four 32-bit words each, which is 16 KB of data. Each line has a tag, a valid bit and a dirty bit. Processor writes allocate a line on a miss and update only the cache. Main memory sees a line again only when a modified line is replaced.

The processor port takes word accesses. A hit is answered two cycles after the request is raised. On a miss the processor is held stalled. If the line being replaced is dirty, the cache first sends that whole 128-bit line to memory. It then fetches the new line, installs it clean, and repeats the lookup, which now hits.

Both sides use valid/ready handshakes with back-pressure. A requester raises valid and keeps valid, the write flag, the address and the write data unchanged until it sees ready high for one cycle. That cycle completes the transfer, and a new request may follow from the next cycle on. On the processor side, ready is the completion strobe. For a read, the word is valid in the same cycle. On the memory side, ready marks the cycle in which the memory accepted a line write or presents read data.

Top module: `dmc_cache`

## Requirements
- R1: After reset no line is valid. Processor ready and memory valid are low, and the first access to any address misses and reads its line from memory.
- R2: Address bits 13:4 select the line and bits 31:14 form the tag. Addresses with equal index and different tags displace each other. Addresses with different indices stay resident together.
- R3: A read hit raises processor ready on the second cycle after the request is raised, with no memory traffic. The read data is the word chosen by address bits 3:2 and equals the last value written to that word (or the memory's contents if it was never written).
- R4: A write hit replaces only the addressed 32-bit word of the line and marks the line dirty. The other three words keep their values.
- R5: A miss whose victim line is clean or invalid makes exactly one memory read. The read uses address {tag, index, 4'b0000} and no memory write takes place.
- R6: A miss whose victim line is dirty first writes the full victim line to {old tag, index, 4'b0000}, carrying the latest data of all four words. After that write is accepted, the cache reads the new line.
- R7: A write miss fetches the line, merges the written word into it, and leaves the line dirty. A later read of the line hits and returns the merged data.
- R8: While memory valid is high and memory ready is low, the memory request's valid, write flag, address and write data stay unchanged.
- R9: Processor ready is low for the whole of any memory transfer and is never high without a processor request.
- R10: A refilled line is installed clean. Evicting it without an intervening write produces no write-back.
- R11: Address bits 1:0 are ignored: all accesses are whole-word accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req_valid | input | 1 | Processor request pending; held until cpu_rsp_ready |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | 32 | Byte address of the access |
| cpu_req_wdata | input | 32 | Store data |
| cpu_rsp_rdata | output | 32 | Load data, valid while cpu_rsp_ready is high |
| cpu_rsp_ready | output | 1 | One-cycle completion strobe for the processor request |
| mem_req_valid | output | 1 | Memory transfer requested; held until mem_rsp_ready |
| mem_req_write | output | 1 | 1 = line write-back, 0 = line fetch |
| mem_req_addr | output | 32 | Line-aligned byte address |
| mem_req_wdata | output | 128 | Victim line for write-back |
| mem_rsp_rdata | input | 128 | Fetched line, sampled while mem_rsp_ready is high |
| mem_rsp_ready | input | 1 | One-cycle strobe: memory accepted the write or returns read data |

## Verification
A corrupted tag, valid or dirty bit shows up at the ports on the next access to that index. Such a bit changes the hit latency from two cycles to a memory transaction, or back. It can also make a write-back appear where none is due, or go missing. A wrong word in the line array can stay hidden until that word is read back or the line is evicted, and only then does it show up as a wrong load value or a wrong write-back line. For that reason the bench compares every load and every write-back line against a reference memory. It also predicts, from a shadow of tag, valid and dirty state, the exact memory traffic of every access.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_EVICT  = 2'd2,
    ST_FILL   = 2'd3
  } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int TAG_W = 18,
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  input  logic             install,
  input  logic [TAG_W-1:0] new_tag,
  input  logic             mark_dirty,
  output logic [TAG_W-1:0] cur_tag,
  output logic             cur_valid,
  output logic             cur_dirty
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0] tag_q [LINES];
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;

  // tags need no reset: valid gates them
  always_ff @(posedge clk) begin
    if (install) tag_q[idx] <= new_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (install) begin
      valid_q[idx] <= 1'b1;
      dirty_q[idx] <= 1'b0;
    end else if (mark_dirty) begin
      dirty_q[idx] <= 1'b1;
    end
  end

  assign cur_tag   = tag_q[idx];
  assign cur_valid = valid_q[idx];
  assign cur_dirty = dirty_q[idx];
endmodule

// File: rtl/dmc_line_store.sv
module dmc_line_store #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int IDX_W  = 10
) (
  input  logic                    clk,
  input  logic [IDX_W-1:0]        idx,
  input  logic                    fill,
  input  logic [WORD_W*WORDS-1:0] fill_line,
  input  logic                    word_we,
  input  logic [$clog2(WORDS)-1:0] word_sel,
  input  logic [WORD_W-1:0]       word_data,
  output logic [WORD_W*WORDS-1:0] cur_line
);
  localparam int LINES  = 1 << IDX_W;
  localparam int WSEL_W = $clog2(WORDS);

  // one bank per word so a store touches a single bank
  for (genvar w = 0; w < WORDS; w++) begin : g_bank
    localparam logic [WSEL_W-1:0] MY_SEL = WSEL_W'(w);
    logic [WORD_W-1:0] bank [LINES];
    logic              bank_we;
    logic [WORD_W-1:0] bank_wd;

    assign bank_we = fill | (word_we && (word_sel == MY_SEL));
    assign bank_wd = fill ? fill_line[w*WORD_W +: WORD_W] : word_data;

    always_ff @(posedge clk) begin
      if (bank_we) bank[idx] <= bank_wd;
    end

    assign cur_line[w*WORD_W +: WORD_W] = bank[idx];
  end
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cpu_valid,
  input  logic cpu_write,
  input  logic hit,
  input  logic victim_dirty,
  input  logic mem_ready,
  output logic cpu_ready,
  output logic mem_valid,
  output logic mem_write,
  output logic install,
  output logic word_we,
  output logic mark_dirty
);
  dmc_state_e st_q, st_d;

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

  always_comb begin
    st_d       = st_q;
    cpu_ready  = 1'b0;
    mem_valid  = 1'b0;
    mem_write  = 1'b0;
    install    = 1'b0;
    word_we    = 1'b0;
    mark_dirty = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (cpu_valid) st_d = ST_LOOKUP;
      end
      ST_LOOKUP: begin
        if (hit) begin
          cpu_ready  = 1'b1;
          word_we    = cpu_write;
          mark_dirty = cpu_write;
          st_d       = ST_IDLE;
        end else if (victim_dirty) begin
          st_d = ST_EVICT;
        end else begin
          st_d = ST_FILL;
        end
      end
      ST_EVICT: begin
        mem_valid = 1'b1;
        mem_write = 1'b1;
        if (mem_ready) st_d = ST_FILL;
      end
      ST_FILL: begin
        mem_valid = 1'b1;
        if (mem_ready) begin
          install = 1'b1;
          st_d    = ST_LOOKUP;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int IDX_W  = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cpu_req_valid,
  input  logic                    cpu_req_write,
  input  logic [ADDR_W-1:0]       cpu_req_addr,
  input  logic [WORD_W-1:0]       cpu_req_wdata,
  output logic [WORD_W-1:0]       cpu_rsp_rdata,
  output logic                    cpu_rsp_ready,
  output logic                    mem_req_valid,
  output logic                    mem_req_write,
  output logic [ADDR_W-1:0]       mem_req_addr,
  output logic [WORD_W*WORDS-1:0] mem_req_wdata,
  input  logic [WORD_W*WORDS-1:0] mem_rsp_rdata,
  input  logic                    mem_rsp_ready
);
  localparam int BYTE_W = $clog2(WORD_W / 8);
  localparam int WSEL_W = $clog2(WORDS);
  localparam int OFF_W  = BYTE_W + WSEL_W;
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_W = WORD_W * WORDS;

  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_idx;
  logic [WSEL_W-1:0] req_word;
  logic [TAG_W-1:0]  cur_tag;
  logic              cur_valid, cur_dirty;
  logic [LINE_W-1:0] cur_line;
  logic              hit, victim_dirty;
  logic              install, word_we, mark_dirty;

  assign req_tag  = cpu_req_addr[ADDR_W-1 -: TAG_W];
  assign req_idx  = cpu_req_addr[OFF_W +: IDX_W];
  assign req_word = cpu_req_addr[BYTE_W +: WSEL_W];

  assign hit          = cur_valid && (cur_tag == req_tag);
  assign victim_dirty = cur_valid && cur_dirty;

  dmc_tag_store #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
    .clk       (clk),
    .rst       (rst),
    .idx       (req_idx),
    .install   (install),
    .new_tag   (req_tag),
    .mark_dirty(mark_dirty),
    .cur_tag   (cur_tag),
    .cur_valid (cur_valid),
    .cur_dirty (cur_dirty)
  );

  dmc_line_store #(.WORD_W(WORD_W), .WORDS(WORDS), .IDX_W(IDX_W)) u_lines (
    .clk      (clk),
    .idx      (req_idx),
    .fill     (install),
    .fill_line(mem_rsp_rdata),
    .word_we  (word_we),
    .word_sel (req_word),
    .word_data(cpu_req_wdata),
    .cur_line (cur_line)
  );

  dmc_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .cpu_valid   (cpu_req_valid),
    .cpu_write   (cpu_req_write),
    .hit         (hit),
    .victim_dirty(victim_dirty),
    .mem_ready   (mem_rsp_ready),
    .cpu_ready   (cpu_rsp_ready),
    .mem_valid   (mem_req_valid),
    .mem_write   (mem_req_write),
    .install     (install),
    .word_we     (word_we),
    .mark_dirty  (mark_dirty)
  );

  // write-back targets the resident line, fetch targets the requested one
  assign mem_req_addr  = {(mem_req_write ? cur_tag : req_tag), req_idx, {OFF_W{1'b0}}};
  assign mem_req_wdata = cur_line;
  assign cpu_rsp_rdata = cur_line[req_word*WORD_W +: WORD_W];
endmodule

// File: rtl/dmc_cache_chk.sv
module dmc_cache_chk #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int IDX_W  = 10
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    cpu_req_valid,
  input logic [ADDR_W-1:0]       cpu_req_addr,
  input logic                    cpu_rsp_ready,
  input logic                    mem_req_valid,
  input logic                    mem_req_write,
  input logic [ADDR_W-1:0]       mem_req_addr,
  input logic [WORD_W*WORDS-1:0] mem_req_wdata,
  input logic                    mem_rsp_ready
);
  localparam int OFF_W = $clog2(WORD_W / 8) + $clog2(WORDS);

  AST_MEM_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_rsp_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)); // R8
  AST_MEM_WDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && mem_req_write && !mem_rsp_ready |=> $stable(mem_req_wdata)); // R8
  AST_READY_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    cpu_rsp_ready |-> cpu_req_valid); // R9
  AST_STALL_DURING_MEM: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !cpu_rsp_ready); // R9
  AST_EVICT_THEN_FILL: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && mem_req_write && mem_rsp_ready |=> mem_req_valid && !mem_req_write); // R6
  AST_EVICT_SAME_SET: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && mem_req_write |-> mem_req_addr[OFF_W +: IDX_W] == cpu_req_addr[OFF_W +: IDX_W]); // R6
  AST_FILL_ADDR: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_write |-> mem_req_addr[ADDR_W-1:OFF_W] == cpu_req_addr[ADDR_W-1:OFF_W]); // R5
  AST_FILL_THEN_QUIET: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_write && mem_rsp_ready |=> !mem_req_valid); // R10
endmodule

bind dmc_cache dmc_cache_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS), .IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cpu_req_valid(cpu_req_valid),
  .cpu_req_addr (cpu_req_addr),
  .cpu_rsp_ready(cpu_rsp_ready),
  .mem_req_valid(mem_req_valid),
  .mem_req_write(mem_req_write),
  .mem_req_addr (mem_req_addr),
  .mem_req_wdata(mem_req_wdata),
  .mem_rsp_ready(mem_rsp_ready)
);

// File: tb/sim_dmc_cache.sv
`timescale 1ns/1ps
module sim_dmc_cache;
  logic         clk = 1'b0;
  logic         rst;
  logic         cpu_req_valid, cpu_req_write;
  logic [31:0]  cpu_req_addr, cpu_req_wdata, cpu_rsp_rdata;
  logic         cpu_rsp_ready;
  logic         mem_req_valid, mem_req_write;
  logic [31:0]  mem_req_addr;
  logic [127:0] mem_req_wdata, mem_rsp_rdata;
  logic         mem_rsp_ready;

  always #5 clk = ~clk;

  dmc_cache u0 (.*);

  int checks = 0;
  int failures = 0;

  // reference contents and shadow of line state
  logic [31:0]  refm [logic [31:0]];
  logic [127:0] bmem [logic [31:0]];
  logic         sv [1024];
  logic [17:0]  st [1024];
  logic         sd [1024];

  // per-access observations from the memory model
  int           acc_rd, acc_wr;
  logic         first_wr;
  logic [31:0]  wb_addr, rd_addr;
  logic [127:0] wb_line;
  int           g_n;
  logic [31:0]  g_rd;

  function automatic logic [31:0] init_word(logic [31:0] wa);
    return (wa * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  function automatic logic [31:0] ref_rd(logic [31:0] a);
    logic [31:0] wa = a >> 2;
    if (refm.exists(wa)) return refm[wa];
    return init_word(wa);
  endfunction

  function automatic logic [127:0] ref_line(logic [31:0] la);
    logic [127:0] l;
    for (int w = 0; w < 4; w++) l[w*32 +: 32] = ref_rd({la[31:4], w[1:0], 2'b00});
    return l;
  endfunction

  function automatic logic [127:0] mem_line(logic [31:0] la);
    logic [127:0] l;
    if (bmem.exists(la >> 4)) return bmem[la >> 4];
    for (int w = 0; w < 4; w++) l[w*32 +: 32] = init_word({la[31:4], w[1:0], 2'b00} >> 2);
    return l;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [127:0] act, input logic [127:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, expv);
    end
  endtask

  // memory model: random latency, one-cycle ready pulse
  initial begin
    int wcnt, lat;
    logic [31:0] h_addr;
    logic        h_wr;
    mem_rsp_ready = 1'b0;
    mem_rsp_rdata = '0;
    wcnt = 0; lat = 1;
    h_addr = '0; h_wr = 1'b0;
    forever begin
      @(negedge clk);
      if (mem_rsp_ready) begin
        mem_rsp_ready = 1'b0;
        wcnt = 0;
      end else if (!rst && mem_req_valid) begin
        if (wcnt == 0) begin
          h_addr = mem_req_addr;
          h_wr   = mem_req_write;
          lat    = $urandom_range(1, 5);
        end else begin
          chk(mem_req_addr == h_addr && mem_req_write == h_wr, "R8 mem request held",
              {mem_req_write, mem_req_addr}, {h_wr, h_addr});
        end
        wcnt++;
        if (wcnt >= lat) begin
          if (mem_req_write) begin
            bmem[mem_req_addr >> 4] = mem_req_wdata;
            if (acc_rd == 0) first_wr = 1'b1;
            acc_wr++;
            wb_addr = mem_req_addr;
            wb_line = mem_req_wdata;
          end else begin
            acc_rd++;
            rd_addr = mem_req_addr;
            mem_rsp_rdata = mem_line(mem_req_addr);
          end
          mem_rsp_ready = 1'b1;
        end
      end
    end
  end

  task automatic access(input logic wr, input logic [31:0] a, input logic [31:0] d);
    logic [9:0]   idx = a[13:4];
    logic [17:0]  tg  = a[31:14];
    logic         e_hit = sv[idx] && st[idx] == tg;
    logic         e_wb  = !e_hit && sv[idx] && sd[idx];
    logic [31:0]  e_wba = {st[idx], idx, 4'b0000};
    logic [127:0] e_wbl = ref_line(e_wba);
    logic [31:0]  e_rd  = ref_rd(a);
    int n = 0;
    acc_rd = 0; acc_wr = 0; first_wr = 1'b0;
    @(posedge clk); #1;
    cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = a; cpu_req_wdata = d;
    do begin
      @(negedge clk);
      n++;
    end while (!cpu_rsp_ready && n < 2000);
    g_rd = cpu_rsp_rdata;
    g_n  = n;
    @(posedge clk); #1;
    cpu_req_valid = 1'b0;
    if (e_hit) chk(n == 2, "R3 hit latency", n, 2);
    else       chk(n > 2, "R5 miss stalls", n, 3);
    chk(acc_rd == (e_hit ? 0 : 1), "R5 line reads", acc_rd, e_hit ? 0 : 1);
    chk(acc_wr == (e_wb ? 1 : 0), "R6 write-backs", acc_wr, e_wb ? 1 : 0);
    if (!e_hit) chk(rd_addr == {a[31:4], 4'b0000}, "R5 fetch address", rd_addr, {a[31:4], 4'b0000});
    if (e_wb) begin
      chk(wb_addr == e_wba, "R6 victim address", wb_addr, e_wba);
      chk(wb_line == e_wbl, "R6 victim line", wb_line, e_wbl);
      chk(first_wr, "R6 write-back before fetch", first_wr, 1);
    end
    if (!wr) chk(g_rd == e_rd, e_hit ? "R3 load data" : "R7 load after fill", g_rd, e_rd);
    else refm[a >> 2] = d;
    sd[idx] = (e_hit ? sd[idx] : 1'b0) | wr;
    sv[idx] = 1'b1;
    st[idx] = tg;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 1024; i++) begin sv[i] = 1'b0; sd[i] = 1'b0; st[i] = '0; end
    acc_rd = 0; acc_wr = 0; first_wr = 1'b0;
    wb_addr = '0; rd_addr = '0; wb_line = '0; g_n = 0; g_rd = '0;
    rst = 1'b1;
    cpu_req_valid = 1'b0; cpu_req_write = 1'b0; cpu_req_addr = '0; cpu_req_wdata = '0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(!cpu_rsp_ready && !mem_req_valid, "R1 idle after reset", {cpu_rsp_ready, mem_req_valid}, 0);

    // R1: first access misses
    access(1'b0, 32'h0000_0040, 0);
    chk(acc_rd == 1, "R1 first access fetches", acc_rd, 1);
    // R11: low byte bits ignored
    access(1'b0, 32'h0000_0043, 0);
    chk(g_rd == ref_rd(32'h40) && g_n == 2, "R11 byte bits ignored", g_rd, ref_rd(32'h40));
    // R4: store hits one word only
    access(1'b1, 32'h0000_0044, 32'hCAFE_0001);
    for (int w = 0; w < 4; w++) begin
      access(1'b0, 32'h0000_0040 + 32'(w*4), 0);
      chk(g_rd == (w == 1 ? 32'hCAFE_0001 : init_word(32'h10 + 32'(w))), "R4 word merge",
          g_rd, (w == 1 ? 32'hCAFE_0001 : init_word(32'h10 + 32'(w))));
    end
    // R2 and R6: conflicting tag evicts dirty line
    access(1'b0, 32'h0000_4040, 0);
    chk(acc_wr == 1 && wb_addr == 32'h40, "R6 dirty eviction", wb_addr, 32'h40);
    access(1'b0, 32'h0000_4050, 0);
    access(1'b0, 32'h0000_4048, 0);
    chk(g_n == 2, "R2 other index stays resident", g_n, 2);
    // R7 and R10: write miss over clean line
    access(1'b1, 32'h0000_8044, 32'h1234_5678);
    chk(acc_wr == 0 && acc_rd == 1, "R10 clean victim not written", acc_wr, 0);
    access(1'b0, 32'h0000_8044, 0);
    chk(g_n == 2 && g_rd == 32'h1234_5678, "R7 allocated store visible", g_rd, 32'h1234_5678);
    access(1'b0, 32'h0000_0044, 0);
    chk(acc_wr == 1 && wb_addr == 32'h8040, "R7 allocated line dirty", wb_addr, 32'h8040);
    // last index boundary
    access(1'b1, 32'h0000_3FFC, 32'hFFFF_0000);
    access(1'b0, 32'h0000_7FFC, 0);
    chk(wb_addr == 32'h3FF0, "R2 top index evicts", wb_addr, 32'h3FF0);

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic [9:0]  ix;
      logic [31:0] a;
      case ($urandom_range(0, 4))
        0: ix = 10'd0;
        1: ix = 10'd4;
        2: ix = 10'd5;
        3: ix = 10'd1023;
        default: ix = 10'd9;
      endcase
      a = {18'($urandom_range(0, 2)), ix, 2'($urandom), 2'($urandom)};
      access($urandom_range(0, 2) == 0, a, $urandom);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule